// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block sits in the dispatch stage of a superscalar front end. Each cycle it looks at one candidate instruction, described by a few decoded flags. It reports whether that candidate may join the dispatch group currently being formed. The answer is one of three verdicts:

- **none**: the candidate may join the group.
- **stall**: the candidate must wait for a new group.
- **insert-no-op**: a filler instruction should be placed first, to avoid a costly pipeline recovery.

The block keeps a count of the group slots already used and remembers whether the group already holds a write to the count register (CTR). An issue strobe commits the candidate to the group. An advance strobe records a cycle in which nothing was dispatched.

The verdict is combinational from the candidate pins and the current state. State changes only on the clock edge. The interface is control-only: the candidate pins are sampled whenever the issue strobe is high. There is no valid/ready handshake and no back-pressure. The scheduler above the block owns the decision to issue, and the block never holds anything back. Whether a load overlaps an earlier store in the group is worked out elsewhere and arrives here on one pin.

Top module: `dgrp_slot_guard`

## Requirements
- R1: After reset the slot count is 0 and no CTR write is remembered. A plain fixed-point candidate (unit code 0) then gets the verdict none.
- R2: A candidate flagged first-only or single gets stall when the slot count is not 0.
- R3: A cracked candidate gets stall when the slot count is greater than 2. When issued, a cracked candidate uses two slots.
- R4: Some candidates get stall when the slot count is 4:
  - unit codes 0 to 4 (fixed-point, load/store, float, vector ALU, vector permute);
  - the reserved code 7.
  A branch (unit code 6) is never stalled because of the slot count alone.
- R5: A condition-register candidate (unit code 5) gets stall when the slot count is 2 or more.
- R6: Issuing a branch or a single candidate closes the group. The slot count returns to 0 and the remembered CTR write clears.
- R7: A candidate gets insert-no-op in either of these cases, provided no stall condition holds:
  - it branches through CTR after a CTR write in the same group;
  - the memory conflict input is high.
- R8: When a stall condition and an insert-no-op condition both hold, the verdict is stall. Verdict codes are: 0 = none, 1 = stall, 2 = insert-no-op.
- R9: An advance strobe adds one to the slot count. When the count would reach 5, the group ends: the count becomes 0 and the remembered CTR write clears.
- R10: A pseudo candidate always gets the verdict none. Issuing a pseudo candidate changes no state.
- R11: Issuing a candidate whose verdict is stall changes no state.
- R12: If advance and issue are high in the same cycle, the error output goes high in that cycle and the advance is ignored. The issue still takes effect.
- R13: A normal issue works as follows:
  - It adds one slot, plus one more if the candidate is cracked.
  - A CTR-write candidate sets the remembered CTR write.
  - When the new count reaches 5 or more, the group ends as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cand_unit | input | 3 | Candidate unit class code |
| cand_first | input | 1 | Candidate must open a group |
| cand_single | input | 1 | Candidate fills a group alone |
| cand_cracked | input | 1 | Candidate splits into two operations |
| cand_ctr_wr | input | 1 | Candidate writes the count register |
| cand_ctr_br | input | 1 | Candidate branches through the count register |
| cand_pseudo | input | 1 | Candidate is a pseudo or debug marker |
| cand_mem_conflict | input | 1 | Candidate load overlaps a store already in the group |
| issue | input | 1 | Commit the candidate to the group |
| advance | input | 1 | Empty dispatch cycle |
| verdict | output | 2 | 0 none, 1 stall, 2 insert-no-op |
| grp_fill | output | 3 | Slots used in the current group |
| adv_err | output | 1 | Advance and issue asserted together |

## Verification
The hardest case to reach from the ports is the CTR branch, for two reasons:

- Its insert-no-op verdict only appears once an earlier CTR write sits in the same, still open group.
- The remembered write is invisible at the ports, because it clears silently when the group closes.

The bench therefore builds each starting state in steps. It resets, optionally issues a CTR-writing fixed-point candidate, and then uses advance strobes to bring the slot count to each value. Every candidate combination is swept from there. After each issue it sends a branch-through-CTR probe, whose verdict reveals whether the write is still remembered.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

  typedef enum logic [2:0] {
    U_FIX   = 3'd0,
    U_LDST  = 3'd1,
    U_FLT   = 3'd2,
    U_VEC   = 3'd3,
    U_VPERM = 3'd4,
    U_CR    = 3'd5,
    U_BR    = 3'd6,
    U_RSV   = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    V_NONE  = 2'd0,
    V_STALL = 2'd1,
    V_NOOP  = 2'd2
  } verdict_e;

  typedef struct packed {
    unit_e unit;
    logic  first;
    logic  single;
    logic  cracked;
    logic  ctr_wr;
    logic  ctr_br;
    logic  pseudo;
    logic  mem_conflict;
  } cand_t;

endpackage

// File: rtl/dgrp_verdict.sv
module dgrp_verdict
  import dgrp_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int CR_SLOTS = 2,
  localparam int CW      = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cand_t         cand,
  input  logic [CW-1:0] fill,
  input  logic          ctr_seen,
  output verdict_e      verdict
);

  localparam logic [CW-1:0] NB_LIMIT    = CW'(SLOTS - 1);
  localparam logic [CW-1:0] CRACK_LIMIT = CW'(SLOTS - 3);
  localparam logic [CW-1:0] CR_LIMIT    = CW'(CR_SLOTS);

  logic non_branch;
  logic stall_open, stall_crack, stall_unit, stall_cr;
  logic stall_any, noop_any;

  always_comb begin
    non_branch  = (cand.unit != U_BR) && (cand.unit != U_CR);
    stall_open  = (fill != '0) && (cand.first || cand.single);
    stall_crack = cand.cracked && (fill > CRACK_LIMIT);
    stall_unit  = non_branch && (fill == NB_LIMIT);
    stall_cr    = (cand.unit == U_CR) && (fill >= CR_LIMIT);
    stall_any   = stall_open || stall_crack || stall_unit || stall_cr;
    noop_any    = (ctr_seen && cand.ctr_br) || cand.mem_conflict;
  end

  always_comb begin
    if (cand.pseudo)     verdict = V_NONE;
    else if (stall_any)  verdict = V_STALL;
    else if (noop_any)   verdict = V_NOOP;
    else                 verdict = V_NONE;
  end

  // R8: only one of the two hazard codes is ever reported
  a_r8_single_code: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(verdict) <= 1);

  // R10: pseudo candidates never see a hazard
  a_r10_pseudo_clean: assert property (@(posedge clk) disable iff (!rst_n)
    cand.pseudo |-> verdict == V_NONE);

  // R2: a group-opening candidate in a non-empty group must wait
  a_r2_first_late: assert property (@(posedge clk) disable iff (!rst_n)
    (!cand.pseudo && fill != '0 && (cand.first || cand.single)) |-> verdict == V_STALL);

endmodule

// File: rtl/dgrp_occupancy.sv
module dgrp_occupancy #(
  parameter int SLOTS = 5,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_go,
  input  logic          close_req,
  input  logic          two_ops,
  input  logic          sets_ctr,
  input  logic          adv_go,
  output logic [CW-1:0] fill,
  output logic          ctr_seen
);

  localparam logic [CW:0] LAST = (CW+1)'(SLOTS - 1);
  localparam logic [CW:0] FULL = (CW+1)'(SLOTS);

  logic [CW:0] base;
  logic [CW:0] next_fill;
  logic        group_end;

  always_comb begin
    base      = close_req ? LAST : {1'b0, fill};
    next_fill = '0;
    group_end = 1'b0;
    if (issue_go) begin
      next_fill = base + 1'b1 + {{CW{1'b0}}, two_ops};
      group_end = next_fill >= FULL;
    end else if (adv_go) begin
      next_fill = {1'b0, fill} + 1'b1;
      group_end = next_fill >= FULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill     <= '0;
      ctr_seen <= 1'b0;
    end else if (issue_go || adv_go) begin
      if (group_end) begin
        fill     <= '0;
        ctr_seen <= 1'b0;
      end else begin
        fill     <= next_fill[CW-1:0];
        ctr_seen <= ctr_seen || (issue_go && sets_ctr);
      end
    end
  end

  // R13: the count never rests at or above the group size
  a_r13_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill < CW'(SLOTS));

  // R9: an advance from the last slot ends the group
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_go && !issue_go && fill == CW'(SLOTS - 1)) |=> (fill == '0 && !ctr_seen));

  // R6: closing issue empties the group
  a_r6_close: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_go && close_req) |=> (fill == '0 && !ctr_seen));

  // R9: a mid-group advance adds exactly one
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_go && !issue_go && fill < CW'(SLOTS - 1)) |=> fill == $past(fill) + 1'b1);

endmodule

// File: rtl/dgrp_slot_guard.sv
module dgrp_slot_guard
  import dgrp_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int CR_SLOTS = 2,
  localparam int CW      = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cand_unit,
  input  logic          cand_first,
  input  logic          cand_single,
  input  logic          cand_cracked,
  input  logic          cand_ctr_wr,
  input  logic          cand_ctr_br,
  input  logic          cand_pseudo,
  input  logic          cand_mem_conflict,
  input  logic          issue,
  input  logic          advance,
  output logic [1:0]    verdict,
  output logic [CW-1:0] grp_fill,
  output logic          adv_err
);

  cand_t    cand;
  verdict_e v;
  logic     ctr_seen;
  logic     issue_go, adv_go, close_req;

  always_comb begin
    cand.unit         = unit_e'(cand_unit);
    cand.first        = cand_first;
    cand.single       = cand_single;
    cand.cracked      = cand_cracked;
    cand.ctr_wr       = cand_ctr_wr;
    cand.ctr_br       = cand_ctr_br;
    cand.pseudo       = cand_pseudo;
    cand.mem_conflict = cand_mem_conflict;
  end

  dgrp_verdict #(.SLOTS(SLOTS), .CR_SLOTS(CR_SLOTS)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (cand),
    .fill     (grp_fill),
    .ctr_seen (ctr_seen),
    .verdict  (v)
  );

  always_comb begin
    issue_go  = issue && !cand_pseudo && (v != V_STALL);
    adv_go    = advance && !issue;
    close_req = (cand.unit == U_BR) || cand_single;
    adv_err   = advance && issue;
    verdict   = v;
  end

  dgrp_occupancy #(.SLOTS(SLOTS)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_go  (issue_go),
    .close_req (close_req),
    .two_ops   (cand_cracked),
    .sets_ctr  (cand_ctr_wr),
    .adv_go    (adv_go),
    .fill      (grp_fill),
    .ctr_seen  (ctr_seen)
  );

  // R11: a stalled issue leaves the group untouched
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && verdict == 2'd1) |=> $stable(grp_fill));

  // R10: issuing a pseudo candidate leaves the group untouched
  a_r10_pseudo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cand_pseudo) |=> $stable(grp_fill));

  // R12: a coincident advance does not move an otherwise idle group
  a_r12_adv_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && issue && cand_pseudo) |=> $stable(grp_fill));

endmodule

// File: tb/tb_dgrp_slot_guard.sv
module tb_dgrp_slot_guard;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cand_unit = '0;
  logic       cand_first = 0, cand_single = 0, cand_cracked = 0;
  logic       cand_ctr_wr = 0, cand_ctr_br = 0, cand_pseudo = 0, cand_mem_conflict = 0;
  logic       issue = 0, advance = 0;
  logic [1:0] verdict;
  logic [2:0] grp_fill;
  logic       adv_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dgrp_slot_guard dut (
    .clk(clk), .rst_n(rst_n), .cand_unit(cand_unit), .cand_first(cand_first),
    .cand_single(cand_single), .cand_cracked(cand_cracked), .cand_ctr_wr(cand_ctr_wr),
    .cand_ctr_br(cand_ctr_br), .cand_pseudo(cand_pseudo),
    .cand_mem_conflict(cand_mem_conflict), .issue(issue), .advance(advance),
    .verdict(verdict), .grp_fill(grp_fill), .adv_err(adv_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cand();
    cand_unit = 3'd0; cand_first = 0; cand_single = 0; cand_cracked = 0;
    cand_ctr_wr = 0; cand_ctr_br = 0; cand_pseudo = 0; cand_mem_conflict = 0;
    issue = 0; advance = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_cand();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step_adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_cand();
      advance = 1;
    end
    @(negedge clk);
    advance = 0;
  endtask

  function automatic int model_verdict(int c, int ctr, int u, int f, int s, int k,
                                       int br, int ps, int mem);
    int st;
    if (ps != 0) return 0;
    st = 0;
    if (c != 0 && (f != 0 || s != 0)) st = 1;           // R2
    if (k != 0 && c > 2) st = 1;                        // R3
    if (u != 5 && u != 6 && c == 4) st = 1;             // R4
    if (u == 5 && c >= 2) st = 1;                       // R5
    if (st != 0) return 1;                              // R8
    if ((ctr != 0 && br != 0) || mem != 0) return 2;    // R7
    return 0;
  endfunction

  initial begin
    int ev, nc, nctr, base, n;
    do_reset();
    #1;
    check("R1 fill", grp_fill, 0);
    check("R1 verdict", verdict, 0);
    cand_unit = 3'd6; cand_ctr_br = 1; #1;
    check("R1 ctr clear", verdict, 0);
    idle_cand();

    // R9: five advances wrap to an empty group
    step_adv(4);
    #1 check("R9 four advances", grp_fill, 4);
    step_adv(1);
    #1 check("R9 wrap", grp_fill, 0);

    // R12: advance with issue of a plain FXU: fill goes to 1, not 2
    @(negedge clk);
    idle_cand(); issue = 1; advance = 1; #1;
    check("R12 adv_err", adv_err, 1);
    @(negedge clk);
    idle_cand(); #1;
    check("R12 advance ignored", grp_fill, 1);
    check("R12 err low", adv_err, 0);

    // exhaustive sweep
    for (int c = 0; c < 5; c++)
      for (int ctr = 0; ctr < 2; ctr++)
        for (int u = 0; u < 8; u++)
          for (int fl = 0; fl < 16; fl++)
            for (int ps = 0; ps < 2; ps++)
              for (int m = 0; m < 2; m++) begin
                if (ctr == 1 && c == 0) continue;
                do_reset();
                if (ctr == 1) begin
                  @(negedge clk);
                  idle_cand(); cand_ctr_wr = 1; issue = 1;
                  @(negedge clk);
                  idle_cand();
                  if (c > 1) step_adv(c - 1);
                end else if (c > 0) step_adv(c);
                @(negedge clk);
                cand_unit = 3'(u); cand_first = fl[0]; cand_single = fl[1];
                cand_cracked = fl[2]; cand_ctr_br = fl[3]; cand_pseudo = ps[0];
                cand_mem_conflict = m[0]; cand_ctr_wr = m[0];
                #1;
                ev = model_verdict(c, ctr, u, fl[0], fl[1], fl[2], fl[3], ps, m);
                check("R2/R3/R4/R5/R7/R8/R10 verdict", verdict, ev);
                issue = 1;
                // expected next state
                if (ps != 0 || ev == 1) begin      // R10, R11
                  nc = c; nctr = ctr;
                end else begin                     // R6, R13
                  base = (u == 6 || fl[1] != 0) ? 4 : c;
                  n = base + 1 + fl[2];
                  if (n >= 5) begin nc = 0; nctr = 0; end
                  else begin nc = n; nctr = (ctr != 0 || m != 0) ? 1 : 0; end
                end
                @(negedge clk);
                idle_cand(); #1;
                check("R6/R11/R13 fill", grp_fill, nc);
                cand_unit = 3'd6; cand_ctr_br = 1; #1;
                check("R6/R13 ctr probe", verdict, (nctr != 0) ? 2 : 0);
                idle_cand();
              end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule